// File: doc/BRIEF.md
# Video Memory Bus with Name-Table Mirroring

This block is the memory side of a tile-based video processor. It takes a 14-bit byte address with separate read and write strobes. It steers each access to one of three stores: an 8 KB tile-pattern store that behaves as ROM, a 2 KB name-table RAM and a 32-byte palette RAM. Large parts of the 16 KB space are folded back onto these stores by mirroring rules.

A static mode input chooses how the four logical 1 KB name tables land in the two physical kilobytes. The pattern store cannot be written from the bus. It is filled through a dedicated preload port before rendering starts. Read data comes back registered, one clock after the read strobe.

Top module: `vram_bus`

## Requirements
- R1: An address below 0x2000 reads the pattern store at that address. Its contents are written only through the preload port (`init_wr`, `init_addr`, `init_data`).
- R2: A bus write to an address below 0x2000 leaves the pattern store unchanged.
- R3: An address of 0x3F00 or above selects palette entry `addr[4:0]`, so the 32 entries repeat up to 0x3FFF.
- R4: Addresses 0x2000 to 0x3EFF select name-table RAM. Address bit 12 does not take part in the index, so 0x3000 to 0x3EFF mirror 0x2000 to 0x2EFF.
- R5: With `mirror_mode` = 1 the name-table index is `addr[10:0]`. Logical tables 0 and 2 therefore share one kilobyte, and tables 1 and 3 share the other.
- R6: With `mirror_mode` = 0 the name-table index is `addr[9:0]` with bit 10 forced to 0. All four logical tables fold onto the first kilobyte.
- R7: A read strobe without a write strobe drives `rvalid` high and places the selected byte on `rdata` on the next clock edge. In every other cycle `rvalid` is low and `rdata` holds its last value.
- R8: A write strobe updates the selected palette or name-table byte on that clock edge. A read of the same location in the following cycle returns the new byte.
- R9: When the read and write strobes are both high, the write takes place and the read is dropped: `rvalid` stays low and `rdata` holds.
- R10: During reset `rdata` is 0x00 and `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| mirror_mode | input | 1 | Name-table folding select (1: bit 10 kept, 0: bit 10 cleared) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, wins over `rd_en` |
| addr | input | 14 | Byte address in the video space |
| wdata | input | 8 | Write data |
| init_wr | input | 1 | Pattern-store preload strobe |
| init_addr | input | 13 | Pattern-store preload address |
| init_data | input | 8 | Pattern-store preload data |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | High in the cycle after an accepted read |

## Verification
The hardest case to reach is an alias landing on the same physical byte. Showing that a write through one logical name table appears through another requires the whole name-table RAM and palette to hold known, distinct bytes first. The stimulus therefore fills every physical location through the bus, using data that depends on the address. It then writes through one alias and reads back through a different alias in each mirroring mode. The mode is switched in the middle of the run, so that the same addresses resolve differently.

// File: rtl/vram_bus.sv
module vram_bus #(
  parameter int DW     = 8,
  parameter int AW     = 14,
  parameter int PAT_AW = 13,
  parameter int NT_AW  = 11,
  parameter int PAL_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mirror_mode,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              init_wr,
  input  logic [PAT_AW-1:0] init_addr,
  input  logic [DW-1:0]     init_data,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);
  localparam int PAT_N = 1 << PAT_AW;
  localparam int NT_N  = 1 << NT_AW;
  localparam int PAL_N = 1 << PAL_AW;

  logic [DW-1:0] pat_mem [PAT_N];
  logic [DW-1:0] nt_mem  [NT_N];
  logic [DW-1:0] pal_mem [PAL_N];

  logic is_pat, is_pal, is_nt, rd_go;
  logic [NT_AW-1:0]  nt_idx;
  logic [PAL_AW-1:0] pal_idx;
  logic [DW-1:0]     rd_mux;

  assign is_pat  = ~addr[AW-1];
  assign is_pal  = &addr[AW-1:8];
  assign is_nt   = addr[AW-1] & ~is_pal;
  assign nt_idx  = {mirror_mode & addr[NT_AW-1], addr[NT_AW-2:0]};
  assign pal_idx = addr[PAL_AW-1:0];
  assign rd_go   = rd_en & ~wr_en;

  always_ff @(posedge clk) begin
    if (init_wr) pat_mem[init_addr] <= init_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && is_nt)  nt_mem[nt_idx]   <= wdata;
    if (wr_en && is_pal) pal_mem[pal_idx] <= wdata;
  end

  always_comb begin
    if (is_pat)     rd_mux = pat_mem[addr[PAT_AW-1:0]];
    else if (is_nt) rd_mux = nt_mem[nt_idx];
    else            rd_mux = pal_mem[pal_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_go;
      if (rd_go) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/vram_bus_chk.sv
module vram_bus_chk #(
  parameter int DW = 8,
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          wr_en,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rvalid); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> !rvalid); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> $stable(rdata)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> (!rvalid && $stable(rdata))); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (rdata == '0 && !rvalid)); // R10
endmodule

bind vram_bus vram_bus_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
  .rdata(rdata), .rvalid(rvalid));

// File: tb/vram_bus_bench.sv
module vram_bus_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, mirror_mode = 1, rd_en = 0, wr_en = 0, init_wr = 0;
  logic [13:0] addr = 0;
  logic [7:0]  wdata = 0, init_data = 0;
  logic [12:0] init_addr = 0;
  logic [7:0]  rdata;
  logic        rvalid;

  vram_bus u_vram_bus (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned tests = 0, fails = 0;
  byte unsigned m_pat [8192];
  byte unsigned m_nt  [2048];
  byte unsigned m_pal [32];
  byte unsigned exp_data = 0;
  bit exp_valid = 0, chk_on = 0;
  string tag = "R10";

  function automatic int map(input int a, input bit mode, output int kind);
    int off;
    if (a >= 16128) begin kind = 2; return (a - 16128) % 32; end
    if (a >= 8192) begin
      kind = 1;
      off = (a - 8192) % 4096;
      return mode ? off % 2048 : off % 1024;
    end
    kind = 0;
    return a;
  endfunction

  function automatic byte unsigned mread(input int a, input bit mode);
    int k, i;
    i = map(a, mode, k);
    if (k == 0) return m_pat[i];
    if (k == 1) return m_nt[i];
    return m_pal[i];
  endfunction

  always @(negedge clk) if (chk_on) begin
    tests++;
    if (rvalid !== exp_valid || rdata !== exp_data) begin
      fails++;
      $display("FAIL %s: rvalid=%0b rdata=%02h expected rvalid=%0b rdata=%02h",
               tag, rvalid, rdata, exp_valid, exp_data);
    end
  end

  task automatic op(input string t, input bit rd, input bit wr, input int a, input int d);
    int k, i;
    @(negedge clk);
    tag = t; rd_en = rd; wr_en = wr; addr = a[13:0]; wdata = d[7:0];
    @(posedge clk); #1;
    if (wr) begin
      i = map(a, mirror_mode, k);
      if (k == 1) m_nt[i] = d[7:0];
      else if (k == 2) m_pal[i] = d[7:0];
      exp_valid = 0;
    end else if (rd) begin
      exp_valid = 1; exp_data = mread(a, mirror_mode);
    end else exp_valid = 0;
    rd_en = 0; wr_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (rdata !== 8'h00 || rvalid !== 1'b0) begin
      fails++; $display("FAIL R10: rdata=%02h rvalid=%0b expected 00/0", rdata, rvalid);
    end
    rst_n = 1;
    for (int i = 0; i < 8192; i++) begin
      @(negedge clk); init_wr = 1; init_addr = i[12:0]; init_data = 8'((i * 7 + 3) ^ (i >> 8));
      m_pat[i] = init_data;
    end
    @(negedge clk); init_wr = 0;
    for (int i = 0; i < 2048; i++) op("R8", 0, 1, 'h2000 + i, (i * 13 + 1) ^ (i >> 8));
    for (int i = 0; i < 32; i++) op("R8", 0, 1, 'h3F00 + i, 'hA0 + i);
    exp_valid = 0; chk_on = 1;
    op("R7", 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) op("R1", 1, 0, (i * 211) % 8192, 0);
    op("R1", 1, 0, 'h1FFF, 0);
    op("R2", 0, 1, 'h0123, 'hEE);
    op("R2", 1, 0, 'h0123, 0);
    op("R3", 1, 0, 'h3F25, 0);
    op("R3", 1, 0, 'h3FFF, 0);
    op("R3", 0, 1, 'h3FE4, 'h11);
    op("R3", 1, 0, 'h3F04, 0);
    op("R4", 1, 0, 'h3123, 0);
    op("R4", 1, 0, 'h3EFF, 0);
    op("R5", 1, 0, 'h2805, 0);
    op("R5", 0, 1, 'h2C05, 'h77);
    op("R5", 1, 0, 'h2405, 0);
    op("R5", 1, 0, 'h2005, 0);
    op("R7", 0, 0, 0, 0);
    op("R7", 0, 0, 'h2405, 0);
    @(negedge clk); mirror_mode = 0;
    op("R6", 1, 0, 'h2410, 0);
    op("R6", 1, 0, 'h2C10, 0);
    op("R6", 0, 1, 'h2810, 'h3C);
    op("R6", 1, 0, 'h2010, 0);
    op("R6", 1, 0, 'h3C10, 0);
    op("R8", 0, 1, 'h2777, 'h99);
    op("R8", 1, 0, 'h2377, 0);
    op("R9", 1, 1, 'h3F02, 'h55);
    op("R9", 1, 0, 'h3F22, 0);
    op("R9", 1, 1, 'h0002, 'h66);
    op("R9", 1, 0, 'h0002, 0);
    @(negedge clk); chk_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule